// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes a two-channel PCM stream carried on three wires (serial data, a bit clock and a word clock that alternates between the channels) and turns it into parallel left and right samples. All three wires are treated as asynchronous. Each one passes through a two-stage synchroniser into the system clock domain, and the receiver detects rising bit-clock edges there. The system clock must therefore run several times faster than the bit clock.

A 2-bit format input selects how the stream is framed. The options are left-justified, I2S (MSB one bit after the word clock transition, left channel on word clock low), right-justified with a selectable word length, and right-justified fixed at 16 bits. Every sample is presented as a 24-bit two's-complement value. When a left word and the right word that follows it have both arrived, the pair is placed on the outputs together with a one-cycle strobe. A zero detector counts consecutive all-zero frames and raises a flag that downstream logic can use to mute the output.

Top module: `aud_ser_rx`

## Requirements
- R1: `fmt_sel` selects the framing: 0 is left-justified, 1 is I2S, 2 is right-justified with the length taken from `wlen_sel`, and 3 is right-justified at 16 bits. Bits are sampled on rising bit-clock edges and arrive MSB first.
- R2: Left-justified: the MSB is the first bit after a word clock change. Word clock high carries the left channel. The first 24 bits of a slot form the sample, and `wlen_sel` has no effect.
- R3: I2S: the MSB arrives one bit after the word clock change. Word clock low carries the left channel. The first 24 bits after the MSB position form the sample.
- R4: Format 2: `wlen_sel` codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. The sample is made of the last N bits before the word clock change and is sign-extended from bit N-1 to 24 bits.
- R5: Format 3 always takes the last 16 bits of a slot, sign-extended to 24, whatever the value of `wlen_sel`.
- R6: `frame_vld` is high for exactly one system cycle for each left word followed by a right word. `left_out` and `right_out` change only in that cycle and hold their values at all other times.
- R7: Reset clears the outputs, the strobe and the zero flag. No word is emitted until one full slot has been seen after reset.
- R8: `zero_flag` rises in the strobe cycle of the ZERO_FRAMES-th consecutive frame whose left and right samples are both zero (2048 by default). It stays high while further zero frames arrive.
- R9: `zero_flag` falls in the strobe cycle of the first frame that has a non-zero sample, and the count of zero frames restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_in | input | 1 | Serial bit clock (asynchronous) |
| word_clk_in | input | 1 | Channel select word clock (asynchronous) |
| ser_data_in | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 2 | Framing select (R1) |
| wlen_sel | input | 2 | Right-justified word length code (R4) |
| left_out | output | 24 | Left sample, sign-extended |
| right_out | output | 24 | Right sample, sign-extended |
| frame_vld | output | 1 | One-cycle strobe when a new pair is presented |
| zero_flag | output | 1 | Sustained all-zero input indicator |

## Verification
The bench builds the receiver with ZERO_FRAMES set to 4 and keeps the default of two synchroniser stages. With this threshold, the rise of the zero flag, the flag holding at saturation and its release on a non-zero sample all fall within a few dozen frames instead of thousands. The bit clock period is eight system cycles on 32-bit slots. That covers every format and every word-length code, including sign extension from the top data bit and the code that format 3 must ignore.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        FMT_LJ   = 2'd0,
        FMT_I2S  = 2'd1,
        FMT_RJ   = 2'd2,
        FMT_RJ16 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic    done;
        logic    is_left;
        sample_t word;
    } word_evt_t;

    function automatic int rj_len(fmt_e f, logic [1:0] code);
        if (f == FMT_RJ16) return 16;
        case (code)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic is_rj(fmt_e f);
        return (f == FMT_RJ) || (f == FMT_RJ16);
    endfunction

    function automatic sample_t sext(sample_t raw, int n);
        sample_t r;
        for (int i = 0; i < SAMPLE_W; i++)
            r[i] = (i < n) ? raw[i] : raw[n-1];
        return r;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck,
    input  logic      ws,
    input  logic      sd,
    input  fmt_e      fmt,
    input  logic [1:0] wlen,
    output word_evt_t evt
);
    logic             sck_q;
    logic             ws_raw_q;
    logic             ws_eff_q;
    logic             armed;
    logic [CNT_W-1:0] bcnt;
    sample_t          acc;
    sample_t          sh;

    logic    rise;
    logic    ws_eff;
    logic    bnd;
    sample_t fin_word;
    logic    fin_left;

    always_comb begin
        rise     = sck & ~sck_q;
        ws_eff   = (fmt == FMT_I2S) ? ws_raw_q : ws;
        bnd      = rise && (ws_eff != ws_eff_q);
        fin_word = is_rj(fmt) ? sext(sh, rj_len(fmt, wlen)) : acc;
        fin_left = (fmt == FMT_I2S) ? ~ws_eff_q : ws_eff_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            ws_raw_q <= 1'b0;
            ws_eff_q <= 1'b0;
            armed    <= 1'b0;
            bcnt     <= '0;
            acc      <= '0;
            sh       <= '0;
            evt      <= '0;
        end else begin
            sck_q    <= sck;
            evt.done <= bnd && armed;
            if (bnd) begin
                evt.word    <= fin_word;
                evt.is_left <= fin_left;
            end
            if (rise) begin
                ws_raw_q <= ws;
                ws_eff_q <= ws_eff;
                sh       <= {sh[SAMPLE_W-2:0], sd};
                if (bnd) begin
                    armed <= 1'b1;
                    acc   <= {sd, {(SAMPLE_W-1){1'b0}}};
                    bcnt  <= CNT_W'(1);
                end else if (int'(bcnt) < SAMPLE_W) begin
                    acc  <= acc | (sample_t'(sd) << (SAMPLE_W - 1 - int'(bcnt)));
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
    import aud_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    output sample_t   left_out,
    output sample_t   right_out,
    output logic      frame_vld,
    output logic      commit,
    output logic      pair_zero
);
    sample_t left_hold;
    logic    have_left;

    always_comb begin
        commit    = evt.done && !evt.is_left && have_left;
        pair_zero = (left_hold == '0) && (evt.word == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_out  <= '0;
            right_out <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= commit;
            if (evt.done && evt.is_left) begin
                left_hold <= evt.word;
                have_left <= 1'b1;
            end else if (commit) begin
                left_out  <= left_hold;
                right_out <= evt.word;
                have_left <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aud_rx_zero.sv
module aud_rx_zero #(
    parameter int ZERO_FRAMES = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic pair_zero,
    output logic zero_flag
);
    localparam int ZW = $clog2(ZERO_FRAMES + 1);

    logic [ZW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (commit) begin
            if (!pair_zero)                  cnt <= '0;
            else if (cnt != ZW'(ZERO_FRAMES)) cnt <= cnt + 1'b1;
        end
    end

    assign zero_flag = (cnt == ZW'(ZERO_FRAMES));
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
    import aud_rx_pkg::*;
#(
    parameter int ZERO_FRAMES = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk_in,
    input  logic                word_clk_in,
    input  logic                ser_data_in,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                frame_vld,
    output logic                zero_flag
);
    logic [2:0] raw_in;
    logic [2:0] syn;
    word_evt_t  evt;
    logic       commit;
    logic       pair_zero;

    assign raw_in = {bit_clk_in, word_clk_in, ser_data_in};

    aud_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    aud_rx_deser u_deser (
        .clk  (clk),
        .rst  (rst),
        .sck  (syn[2]),
        .ws   (syn[1]),
        .sd   (syn[0]),
        .fmt  (fmt_e'(fmt_sel)),
        .wlen (wlen_sel),
        .evt  (evt)
    );

    aud_rx_pair u_pair (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .left_out  (left_out),
        .right_out (right_out),
        .frame_vld (frame_vld),
        .commit    (commit),
        .pair_zero (pair_zero)
    );

    aud_rx_zero #(.ZERO_FRAMES(ZERO_FRAMES)) u_zero (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .pair_zero (pair_zero),
        .zero_flag (zero_flag)
    );
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic [23:0] left_out,
    input logic [23:0] right_out,
    input logic        frame_vld,
    input logic        zero_flag
);
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> !frame_vld); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |-> ($stable(left_out) && $stable(right_out))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!frame_vld && !zero_flag)); // R7

    AST_FLAG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |-> $stable(zero_flag)); // R8

    AST_FLAG_RISE_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_flag) |-> (frame_vld && left_out == '0 && right_out == '0)); // R8

    AST_FLAG_CLEAR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && (left_out != '0 || right_out != '0)) |-> !zero_flag); // R9
endmodule

bind aud_ser_rx aud_ser_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .left_out  (left_out),
    .right_out (right_out),
    .frame_vld (frame_vld),
    .zero_flag (zero_flag)
);

// File: tb/aud_ser_rx_bench.sv
module aud_ser_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;
    localparam int SLOT       = 32;
    localparam int ZF         = 4;
    localparam int NVEC       = 10;

    // {fmt, wlen, stim_left, stim_right, exp_left, exp_right}
    localparam logic [99:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 24'h123456, 24'hABCDEF, 24'h123456, 24'hABCDEF},
        {2'd0, 2'd3, 24'h800001, 24'h7FFFFE, 24'h800001, 24'h7FFFFE},
        {2'd1, 2'd0, 24'hA5A5A5, 24'h5A5A5A, 24'hA5A5A5, 24'h5A5A5A},
        {2'd1, 2'd2, 24'hFFFFFF, 24'h000001, 24'hFFFFFF, 24'h000001},
        {2'd2, 2'd0, 24'h008001, 24'h007FFF, 24'hFF8001, 24'h007FFF},
        {2'd2, 2'd1, 24'h020000, 24'h01FFFF, 24'hFE0000, 24'h01FFFF},
        {2'd2, 2'd2, 24'h080000, 24'h012345, 24'hF80000, 24'h012345},
        {2'd2, 2'd3, 24'h876543, 24'h00FF00, 24'h876543, 24'h00FF00},
        {2'd3, 2'd3, 24'h00C000, 24'h001234, 24'hFFC000, 24'h001234},
        {2'd3, 2'd1, 24'h007001, 24'h00F00F, 24'h007001, 24'hFFF00F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdat = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wlen = 2'd0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        frame_vld;
    logic        zero_flag;

    int          checks = 0;
    int          failures = 0;
    int          vld_cnt = 0;
    logic [23:0] got_l = '0;
    logic [23:0] got_r = '0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_ser_rx #(.ZERO_FRAMES(ZF)) u_aud_ser_rx (
        .clk         (clk),
        .rst         (rst),
        .bit_clk_in  (bclk),
        .word_clk_in (wclk),
        .ser_data_in (sdat),
        .fmt_sel     (fmt),
        .wlen_sel    (wlen),
        .left_out    (left_out),
        .right_out   (right_out),
        .frame_vld   (frame_vld),
        .zero_flag   (zero_flag)
    );

    always @(negedge clk) begin
        if (frame_vld) begin
            vld_cnt <= vld_cnt + 1;
            got_l   <= left_out;
            got_r   <= right_out;
        end
    end

    task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        bclk = 1'b0; wclk = w; sdat = d;
        repeat (HALF_BIT - 1) @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        repeat (HALF_BIT - 1) @(negedge clk);
    endtask

    function automatic int len_of(input logic [1:0] f, input logic [1:0] w);
        if (f == 2'd3) return 16;
        return (w == 2'd0) ? 16 : (w == 2'd1) ? 18 : (w == 2'd2) ? 20 : 24;
    endfunction

    task automatic send_slot(input logic w, input logic [23:0] data);
        int n;
        n = len_of(fmt, wlen);
        for (int pos = 0; pos < SLOT; pos++) begin
            logic b;
            b = 1'b0;
            if (fmt == 2'd0)      b = (pos < 24) ? data[23-pos] : 1'b0;
            else if (fmt == 2'd1) b = (pos >= 1 && pos <= 24) ? data[24-pos] : 1'b0;
            else                  b = (pos >= SLOT - n) ? data[SLOT-1-pos] : 1'b0;
            send_bit(w, b);
        end
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
        logic lw;
        lw = (fmt == 2'd1) ? 1'b0 : 1'b1;
        send_slot(lw, l);
        send_slot(~lw, r);
    endtask

    task automatic begin_run(input logic [1:0] f, input logic [1:0] w);
        @(negedge clk);
        rst = 1'b1; fmt = f; wlen = w;
        bclk = 1'b0; sdat = 1'b0;
        wclk = (f == 2'd1) ? 1'b1 : 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        send_bit(wclk, 1'b0);
        send_bit(wclk, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R7: reset state
        repeat (4) @(negedge clk);
        check("R7", "left_out in reset", left_out, 24'h0);
        check("R7", "right_out in reset", right_out, 24'h0);
        check("R7", "frame_vld in reset", {23'h0, frame_vld}, 24'h0);
        check("R7", "zero_flag in reset", {23'h0, zero_flag}, 24'h0);

        // R1..R6: table of formats and lengths
        for (int i = 0; i < NVEC; i++) begin
            logic [99:0] v;
            int base;
            v = VEC[i];
            begin_run(v[99:98], v[97:96]);
            base = vld_cnt;
            send_frame(v[95:72], v[71:48]);
            check("R7", "no strobe before frame completes", 24'(vld_cnt - base), 24'd0);
            send_frame(24'h0, 24'h0);
            repeat (10) @(negedge clk);
            check("R6", "one strobe per frame", 24'(vld_cnt - base), 24'd1);
            case (v[99:98])
                2'd0: check("R2", "left-justified left", got_l, v[47:24]);
                2'd1: check("R3", "I2S left", got_l, v[47:24]);
                2'd2: check("R4", "rj variable left", got_l, v[47:24]);
                default: check("R5", "rj16 left", got_l, v[47:24]);
            endcase
            case (v[99:98])
                2'd0: check("R2", "left-justified right", got_r, v[23:0]);
                2'd1: check("R3", "I2S right", got_r, v[23:0]);
                2'd2: check("R4", "rj variable right", got_r, v[23:0]);
                default: check("R5", "rj16 right", got_r, v[23:0]);
            endcase
            check("R1", "outputs hold after strobe", left_out, v[47:24]);
        end

        // R8 / R9: zero detector with threshold 4
        begin_run(2'd0, 2'd0);
        for (int k = 0; k < 4; k++) send_frame(24'h0, 24'h0);
        check("R8", "flag low after three zero frames", {23'h0, zero_flag}, 24'h0);
        send_frame(24'h0, 24'h0);
        check("R8", "flag high after four zero frames", {23'h0, zero_flag}, 24'h1);
        send_frame(24'h0, 24'h0);
        check("R8", "flag held while zeros continue", {23'h0, zero_flag}, 24'h1);
        send_frame(24'h0, 24'h000001);
        check("R8", "flag still high before non-zero frame completes", {23'h0, zero_flag}, 24'h1);
        send_frame(24'h0, 24'h0);
        check("R9", "flag cleared by non-zero sample", {23'h0, zero_flag}, 24'h0);
        send_frame(24'h0, 24'h0);
        check("R9", "count restarted after non-zero", {23'h0, zero_flag}, 24'h0);

        // R7: reset in mid stream clears flag and outputs
        begin_run(2'd0, 2'd0);
        check("R7", "left_out after reset", left_out, 24'h0);
        check("R7", "zero_flag after reset", {23'h0, zero_flag}, 24'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule